// File: doc/BRIEF.md
# Debounced Pushbutton Digit Stepper

This block takes the raw level of a mechanical pushbutton and uses it to set one BCD digit of a stopwatch. Everything runs on the single system clock. The button is never used as a clock. It passes through a flip-flop synchronizer and then a stability filter. A rising-edge detector on the filtered level then gives exactly one step command per press.

The digit has two sources of advance. One is the press command. The other is a timebase tick from the lower part of the stopwatch, such as the carry out of the next lower digit. Both advance the digit modulo ten. While the filtered button is held down, the block raises a freeze flag. This flag tells the timebase to stop, and the digit itself ignores ticks for as long as it is set. The block also brings out the single-cycle step command, so that a neighbour can see that the digit was set by hand.

Top module: `btn_digit_step`

## Requirements
- R1: The raw button passes through `SYNC_STAGES` flip-flops (default 2) before any other logic. After a clean rise of `btn_raw`, `hold` rises exactly `SYNC_STAGES + DEBOUNCE_CYCLES` rising clock edges later.
- R2: A level change is accepted only after the synchronized input has kept it for `DEBOUNCE_CYCLES` consecutive cycles. A press shorter than that window changes neither `hold`, `step_pulse` nor `digit`.
- R3: A press that chatters, with bounces shorter than the filter window, advances the digit exactly once.
- R4: `step_pulse` is high for exactly one cycle per accepted press. It comes in the same cycle in which `hold` first reads 1, and no pulse comes on release.
- R5: Each accepted press adds one to `digit`, and the new value is visible one cycle after the pulse. The digit then keeps that value for as long as the button stays held.
- R6: The digit counts 0 through 9 and goes back to 0 on the next advance after 9.
- R7: `hold` equals the filtered button level. While it is 1, `tick` has no effect on `digit`.
- R8: With `hold` at 0, each cycle with `tick` high advances `digit` by one, modulo ten.
- R9: When `tick` and `step_pulse` are high in the same cycle, the digit advances only once.
- R10: The asynchronous reset `rst` (active high) clears `digit` to 0 and clears `hold` and `step_pulse`. If the button stays released after reset, no step pulse follows.
- R11: `digit` never holds a value above 9. Any out-of-range value found at update time is replaced by 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the only clock in the block |
| rst | input | 1 | Asynchronous reset, active high |
| btn_raw | input | 1 | Raw pushbutton level, 1 = pressed, asynchronous |
| tick | input | 1 | Timebase advance request for the digit |
| digit | output | 4 | Current BCD digit value, 0 to 9 |
| step_pulse | output | 1 | One-cycle pulse per accepted press |
| hold | output | 1 | Filtered button level; tells the timebase to freeze |

## Verification
The collision of interest is a press step and a timebase tick falling in the same cycle. The bench provokes it by counting the synchronizer and filter latency from the moment it raises the button. It then drives `tick` high for the single cycle in which `step_pulse` is expected. The bench judges the collision by checking that the pulse was indeed present in that cycle and that `digit` rose by exactly one on the next edge, not by two. A second overlap, ticks arriving while the button is held, is checked by confirming that the digit stays frozen.

// File: rtl/btn_digit_pkg.sv
package btn_digit_pkg;

   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;
   localparam bcd_t BCD_TOP = bcd_t'(9);

   // Modulo-ten successor; anything out of range restarts at zero.
   function automatic bcd_t bcd_next(input bcd_t cur);
      if (cur >= BCD_TOP) return bcd_t'(0);
      return cur + bcd_t'(1);
   endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("btn_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
   parameter int CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_in,
   output logic level
);
   generate
      if (CYCLES < 0) begin : g_bad_window
         $error("btn_debounce: CYCLES must not be negative");
      end

      if (CYCLES == 0) begin : g_bypass
         assign level = sync_in;
      end else begin : g_filter
         localparam int CW = $clog2(CYCLES + 1);
         localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

         logic [CW-1:0] cnt_q;
         logic          lvl_q;

         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               cnt_q <= '0;
               lvl_q <= 1'b0;
            end else if (sync_in == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               lvl_q <= sync_in;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end

         assign level = lvl_q;

         // The accepted level may only move at the end of a full window.
         p_window_gate_r2: assert property (@(posedge clk) disable iff (rst)
            (cnt_q != LAST) |=> $stable(lvl_q));

         p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= LAST);
      end
   endgenerate

endmodule

// File: rtl/btn_rise.sv
module btn_rise (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= level;
   end

   assign pulse = level & ~prev_q;

   p_single_cycle_r4: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse);

endmodule

// File: rtl/bcd_step_digit.sv
module bcd_step_digit
   import btn_digit_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic freeze,
   input  logic tick,
   output bcd_t value
);
   bcd_t val_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)                    val_q <= '0;
      else if (step)              val_q <= bcd_next(val_q);
      else if (tick && !freeze)   val_q <= bcd_next(val_q);
   end

   assign value = val_q;

   p_in_range_r11: assert property (@(posedge clk) disable iff (rst)
      val_q <= BCD_TOP);

   p_step_adds_one_r5: assert property (@(posedge clk) disable iff (rst)
      (step && val_q < BCD_TOP) |=> (val_q == $past(val_q) + bcd_t'(1)));

   p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
      (step && val_q == BCD_TOP) |=> (val_q == '0));

   p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
      (freeze && !step) |=> $stable(val_q));

   p_tick_free_r8: assert property (@(posedge clk) disable iff (rst)
      (tick && !freeze && !step && val_q < BCD_TOP) |=> (val_q == $past(val_q) + bcd_t'(1)));

   p_idle_r5: assert property (@(posedge clk) disable iff (rst)
      (!step && !tick) |=> $stable(val_q));

endmodule

// File: rtl/btn_digit_step.sv
module btn_digit_step
   import btn_digit_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 1_000_000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       btn_raw,
   input  logic       tick,
   output logic [3:0] digit,
   output logic       step_pulse,
   output logic       hold
);
   logic btn_sync_w;
   logic btn_level_w;
   logic rise_w;
   bcd_t digit_w;

   btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (btn_raw),
      .dout (btn_sync_w)
   );

   btn_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_filter (
      .clk     (clk),
      .rst     (rst),
      .sync_in (btn_sync_w),
      .level   (btn_level_w)
   );

   btn_rise u_edge (
      .clk   (clk),
      .rst   (rst),
      .level (btn_level_w),
      .pulse (rise_w)
   );

   bcd_step_digit u_digit (
      .clk    (clk),
      .rst    (rst),
      .step   (rise_w),
      .freeze (btn_level_w),
      .tick   (tick),
      .value  (digit_w)
   );

   assign digit      = digit_w;
   assign step_pulse = rise_w;
   assign hold       = btn_level_w;

   p_pulse_in_hold_r4: assert property (@(posedge clk) disable iff (rst)
      step_pulse |-> hold);

   p_collision_once_r9: assert property (@(posedge clk) disable iff (rst)
      (step_pulse && tick && digit < 4'd9) |=> (digit == $past(digit) + 4'd1));

endmodule

// File: tb/btn_digit_step_test.sv
`timescale 1ns/1ps
module btn_digit_step_test;
   localparam int SS = 2;
   localparam int DB = 8;
   localparam int LAT = SS + DB;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       btn_raw = 1'b0;
   logic       tick = 1'b0;
   logic [3:0] digit;
   logic       step_pulse;
   logic       hold;

   int n_checks = 0;
   int n_fail   = 0;
   int pulses   = 0;
   int run_err  = 0;
   int range_err = 0;
   logic prev_pulse = 1'b0;
   int exp_digit = 0;
   bit done = 0;

   always #10 clk = ~clk;

   btn_digit_step #(.SYNC_STAGES(SS), .DEBOUNCE_CYCLES(DB)) uut (
      .clk(clk), .rst(rst), .btn_raw(btn_raw), .tick(tick),
      .digit(digit), .step_pulse(step_pulse), .hold(hold)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (step_pulse) pulses++;
         if (step_pulse && prev_pulse) run_err++;
         if (digit > 4'd9) range_err++;
         prev_pulse <= step_pulse;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // Clean press held long enough, then clean release.
   task automatic press_clean();
      btn_raw = 1'b1;
      edges(LAT + 3);
      btn_raw = 1'b0;
      edges(LAT + 3);
   endtask

   task automatic one_tick();
      tick = 1'b1;
      edges(1);
      tick = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int base;
      @(negedge clk);
      // R10 reset state
      check(digit == 4'd0, "R10 digit in reset", digit, 0);
      check(hold == 1'b0, "R10 hold in reset", hold, 0);
      check(step_pulse == 1'b0, "R10 pulse in reset", step_pulse, 0);
      edges(2);
      rst = 1'b0;
      edges(20);
      check(pulses == 0, "R10 no pulse after reset", pulses, 0);
      check(digit == 4'd0, "R10 digit after reset", digit, 0);

      // R1 latency, R4 pulse timing, R5 single step while held
      btn_raw = 1'b1;
      edges(LAT - 1);
      check(hold == 1'b0, "R1 hold one edge early", hold, 0);
      edges(1);
      check(hold == 1'b1, "R1 hold at latency", hold, 1);
      check(step_pulse == 1'b1, "R4 pulse with hold", step_pulse, 1);
      check(digit == 4'd0, "R5 digit before update", digit, 0);
      edges(1);
      exp_digit = 1;
      check(step_pulse == 1'b0, "R4 pulse one cycle", step_pulse, 0);
      check(digit == 4'(exp_digit), "R5 digit after press", digit, exp_digit);
      edges(25);
      check(digit == 4'(exp_digit), "R5 digit kept while held", digit, exp_digit);
      check(pulses == 1, "R5 one pulse while held", pulses, 1);
      btn_raw = 1'b0;
      edges(LAT + 3);
      check(pulses == 1, "R4 no pulse on release", pulses, 1);
      check(hold == 1'b0, "R7 hold drops on release", hold, 0);

      // R2 short press rejected
      base = pulses;
      btn_raw = 1'b1;
      edges(DB - 2);
      btn_raw = 1'b0;
      edges(LAT + 3);
      check(pulses == base, "R2 short press pulses", pulses - base, 0);
      check(digit == 4'(exp_digit), "R2 short press digit", digit, exp_digit);

      // R3 chattering press and release
      base = pulses;
      btn_raw = 1'b1; edges(3);
      btn_raw = 1'b0; edges(2);
      btn_raw = 1'b1; edges(4);
      btn_raw = 1'b0; edges(1);
      btn_raw = 1'b1; edges(3 * DB);
      btn_raw = 1'b0; edges(2);
      btn_raw = 1'b1; edges(3);
      btn_raw = 1'b0; edges(3 * DB);
      exp_digit = (exp_digit + 1) % 10;
      check(pulses - base == 1, "R3 bounce pulse count", pulses - base, 1);
      check(digit == 4'(exp_digit), "R3 bounce digit", digit, exp_digit);

      // R5/R6 press sweep through wrap
      for (int i = 0; i < 12; i++) begin
         press_clean();
         exp_digit = (exp_digit + 1) % 10;
         check(digit == 4'(exp_digit), "R6 press sweep", digit, exp_digit);
      end

      // R8 ticks while released
      for (int i = 0; i < 15; i++) begin
         one_tick();
         edges(1);
         exp_digit = (exp_digit + 1) % 10;
         check(digit == 4'(exp_digit), "R8 tick sweep", digit, exp_digit);
      end

      // R7 ticks ignored while held
      btn_raw = 1'b1;
      edges(LAT + 3);
      exp_digit = (exp_digit + 1) % 10;
      for (int i = 0; i < 5; i++) begin
         one_tick();
         edges(1);
      end
      check(hold == 1'b1, "R7 hold while pressed", hold, 1);
      check(digit == 4'(exp_digit), "R7 ticks frozen", digit, exp_digit);
      btn_raw = 1'b0;
      edges(LAT + 3);

      // R9 tick in the pulse cycle
      for (int k = 0; k < 10; k++) begin
         btn_raw = 1'b1;
         edges(LAT);
         check(step_pulse == 1'b1, "R9 pulse present", step_pulse, 1);
         tick = 1'b1;
         edges(1);
         tick = 1'b0;
         exp_digit = (exp_digit + 1) % 10;
         check(digit == 4'(exp_digit), "R9 single advance", digit, exp_digit);
         btn_raw = 1'b0;
         edges(LAT + 3);
      end

      check(run_err == 0, "R4 pulse runs", run_err, 0);
      check(range_err == 0, "R11 digit range", range_err, 0);
      finish_run();
   end
endmodule